// File: doc/BRIEF.md
# Idle Mode Clock Gating Controller

This controller decides, cycle by cycle, whether the CPU clock and the peripheral clock may tick, and which oscillator feeds them. While the CPU runs, the controller follows a 2-bit source choice. A sleep strobe then sends it into one of two low-power states. With the idle bit set it enters idle, where only the CPU clock stops and the peripherals keep running from the chosen source. With the idle bit clear it enters full sleep, where both clocks stop.

Only three events bring the CPU back: an interrupt, a watchdog expiry or a reset. Wake-up does not touch the software-owned controls. The CPU therefore resumes on the same source it idled on. Requests to idle on the secondary oscillator are refused while that oscillator is disabled. When the primary oscillator is no longer selected, the controller asks for it to be shut down, unless some other consumer still needs it. Every output comes from a register.

Top module: `idle_clkgate_ctrl`

## Requirements
- R1: With `idle_en`=1, a `sleep_req` pulse sampled in run mode drives `cpu_clk_en` low one cycle later. `per_clk_en` stays high while the selected oscillator is ready.
- R2: While `cpu_clk_en` is low, the CPU clock stays gated unless `irq_wake`, `wdt_wake` or `rst` is sampled high. Further `sleep_req` pulses and changes on `clk_sel` do not restart it.
- R3: A wake event sampled in idle or sleep sets `cpu_clk_en` high one cycle later. At that point `src_sel` still holds the value it had during idle.
- R4: `src_sel` encodes the source: 00 is primary, 01 is secondary, 10 and 11 are internal. In run mode it takes `clk_sel` one cycle later. While the CPU is gated it holds its value.
- R5: A sleep request with `idle_en`=1, `clk_sel`=01 and `sec_osc_en`=0 is ignored, and `cpu_clk_en` stays high.
- R6: `pri_running` is 1 exactly when `src_sel`=00. `sec_running` is 1 exactly when `src_sel`=01. Both flags are 0 for the internal source, and they are never both 1.
- R7: `pri_off_req` is 1 when `src_sel` is not 00 and `pri_keep` is 0. It tracks `pri_keep` with one cycle of delay.
- R8: `per_clk_en` is 0 one cycle after the selected oscillator reports not ready: `pri_rdy` for 00, `sec_rdy` for 01. It returns to 1 one cycle after ready is asserted.
- R9: With `idle_en`=0, a sleep request drives both `cpu_clk_en` and `per_clk_en` low one cycle later. The same wake sources restore both.
- R10: A reset gives `cpu_clk_en`=1, `per_clk_en`=1, `src_sel`=00, `pri_running`=1, `sec_running`=0 and `pri_off_req`=0 one cycle later, from any state.
- R11: If a sleep request and a wake event arrive in the same run-mode cycle, the sleep request is taken. If they arrive in the same cycle while gated, the wake is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset, also a wake source |
| sleep_req | input | 1 | One-cycle sleep strobe |
| idle_en | input | 1 | 1 selects idle, 0 selects full sleep |
| clk_sel | input | SEL_W | Requested clock source |
| sec_osc_en | input | 1 | Secondary oscillator enabled |
| irq_wake | input | 1 | Interrupt wake event |
| wdt_wake | input | 1 | Watchdog expiry wake event |
| pri_rdy | input | 1 | Primary oscillator stable |
| sec_rdy | input | 1 | Secondary oscillator stable |
| pri_keep | input | 1 | Another consumer needs the primary oscillator |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| src_sel | output | SEL_W | Clock mux control |
| pri_off_req | output | 1 | Request to stop the primary oscillator |
| pri_running | output | 1 | Primary source active |
| sec_running | output | 1 | Secondary source active |

## Verification
A sleep request and a wake event can be sampled in the same cycle, and the outcome depends on the mode the controller is already in. The bench drives both strobes high on one clock edge. It does this once from run mode, where the sleep request must take effect and the CPU clock must drop. It does it again from idle, where the wake must take effect and the CPU clock must return. In each case it checks `cpu_clk_en` one cycle after that edge.

// File: rtl/idlectl_pkg.sv
package idlectl_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2
  } mode_e;

  localparam int unsigned SEL_W    = 2;
  localparam logic [SEL_W-1:0] SRC_PRI = 2'b00;
  localparam logic [SEL_W-1:0] SRC_SEC = 2'b01;
endpackage

// File: rtl/idlectl_mode_fsm.sv
module idlectl_mode_fsm
  import idlectl_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          idle_en,
  input  logic [SW-1:0] clk_sel,
  input  logic          sec_osc_en,
  input  logic          wake,
  output mode_e         mode_q,
  output mode_e         mode_d
);
  logic sec_refused;

  assign sec_refused = idle_en && (clk_sel == SW'(SRC_SEC)) && !sec_osc_en;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (sleep_req && !sec_refused) begin
          mode_d = idle_en ? MODE_IDLE : MODE_SLEEP;
        end
      end
      MODE_IDLE, MODE_SLEEP: begin
        if (wake) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RUN;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/idlectl_src_track.sv
module idlectl_src_track
  import idlectl_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_run,
  input  logic [SW-1:0] clk_sel,
  input  logic          pri_keep,
  output logic [SW-1:0] src_d,
  output logic [SW-1:0] src_q,
  output logic          pri_running,
  output logic          sec_running,
  output logic          pri_off_req
);
  assign src_d = in_run ? clk_sel : src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q       <= SW'(SRC_PRI);
      pri_running <= 1'b1;
      sec_running <= 1'b0;
      pri_off_req <= 1'b0;
    end else begin
      src_q       <= src_d;
      pri_running <= (src_d == SW'(SRC_PRI));
      sec_running <= (src_d == SW'(SRC_SEC));
      pri_off_req <= (src_d != SW'(SRC_PRI)) && !pri_keep;
    end
  end
endmodule

// File: rtl/idlectl_clk_out.sv
module idlectl_clk_out
  import idlectl_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  mode_e         mode_d,
  input  logic [SW-1:0] src_d,
  input  logic          pri_rdy,
  input  logic          sec_rdy,
  output logic          cpu_clk_en,
  output logic          per_clk_en
);
  logic src_ready;

  always_comb begin
    if (src_d == SW'(SRC_PRI))      src_ready = pri_rdy;
    else if (src_d == SW'(SRC_SEC)) src_ready = sec_rdy;
    else                            src_ready = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
    end else begin
      cpu_clk_en <= (mode_d == MODE_RUN);
      per_clk_en <= (mode_d != MODE_SLEEP) && src_ready;
    end
  end
endmodule

// File: rtl/idle_clkgate_ctrl.sv
module idle_clkgate_ctrl
  import idlectl_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          idle_en,
  input  logic [SW-1:0] clk_sel,
  input  logic          sec_osc_en,
  input  logic          irq_wake,
  input  logic          wdt_wake,
  input  logic          pri_rdy,
  input  logic          sec_rdy,
  input  logic          pri_keep,
  output logic          cpu_clk_en,
  output logic          per_clk_en,
  output logic [SW-1:0] src_sel,
  output logic          pri_off_req,
  output logic          pri_running,
  output logic          sec_running
);
  mode_e         mode_q;
  mode_e         mode_d;
  logic [SW-1:0] src_d;
  logic          wake;

  assign wake = irq_wake || wdt_wake;

  idlectl_mode_fsm #(.SW(SW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .idle_en    (idle_en),
    .clk_sel    (clk_sel),
    .sec_osc_en (sec_osc_en),
    .wake       (wake),
    .mode_q     (mode_q),
    .mode_d     (mode_d)
  );

  idlectl_src_track #(.SW(SW)) u_src (
    .clk         (clk),
    .rst         (rst),
    .in_run      (mode_q == MODE_RUN),
    .clk_sel     (clk_sel),
    .pri_keep    (pri_keep),
    .src_d       (src_d),
    .src_q       (src_sel),
    .pri_running (pri_running),
    .sec_running (sec_running),
    .pri_off_req (pri_off_req)
  );

  idlectl_clk_out #(.SW(SW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .mode_d     (mode_d),
    .src_d      (src_d),
    .pri_rdy    (pri_rdy),
    .sec_rdy    (sec_rdy),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en)
  );
endmodule

// File: rtl/idlectl_checker.sv
module idlectl_checker #(
  parameter int unsigned SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep_req,
  input logic          idle_en,
  input logic [SW-1:0] clk_sel,
  input logic          sec_osc_en,
  input logic          irq_wake,
  input logic          wdt_wake,
  input logic          pri_rdy,
  input logic          sec_rdy,
  input logic          pri_keep,
  input logic          cpu_clk_en,
  input logic          per_clk_en,
  input logic [SW-1:0] src_sel,
  input logic          pri_off_req,
  input logic          pri_running,
  input logic          sec_running
);
  logic idle_ok;
  assign idle_ok = (clk_sel != SW'(1)) || sec_osc_en;

  AST_IDLE_GATES_CPU: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && idle_en && idle_ok) |=> !cpu_clk_en); // R1
  AST_STAYS_GATED: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && !irq_wake && !wdt_wake) |=> !cpu_clk_en); // R2
  AST_WAKE_RESUMES: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && (irq_wake || wdt_wake)) |=> cpu_clk_en); // R3
  AST_SRC_HELD: assert property (@(posedge clk) disable iff (rst)
    !cpu_clk_en |=> $stable(src_sel)); // R4
  AST_SEC_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && idle_en && clk_sel == SW'(1) && !sec_osc_en) |=> cpu_clk_en); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pri_running, sec_running})); // R6
  AST_SEC_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && clk_sel == SW'(1) && !sec_rdy) |=> !per_clk_en); // R8
  AST_FULL_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && sleep_req && !idle_en) |=> (!cpu_clk_en && !per_clk_en)); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cpu_clk_en && pri_running && !sec_running && !pri_off_req)); // R10
endmodule

bind idle_clkgate_ctrl idlectl_checker #(.SW(SW)) chk_i (.*);

// File: tb/idle_clkgate_ctrl_tb_top.sv
module idle_clkgate_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_req = 1'b0, idle_en = 1'b1, sec_osc_en = 1'b1;
  logic [1:0] clk_sel = 2'b00;
  logic       irq_wake = 1'b0, wdt_wake = 1'b0;
  logic       pri_rdy = 1'b1, sec_rdy = 1'b1, pri_keep = 1'b0;
  logic       cpu_clk_en, per_clk_en, pri_off_req, pri_running, sec_running;
  logic [1:0] src_sel;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  idle_clkgate_ctrl dut_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .idle_en(idle_en),
    .clk_sel(clk_sel), .sec_osc_en(sec_osc_en), .irq_wake(irq_wake),
    .wdt_wake(wdt_wake), .pri_rdy(pri_rdy), .sec_rdy(sec_rdy),
    .pri_keep(pri_keep), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .src_sel(src_sel), .pri_off_req(pri_off_req), .pri_running(pri_running),
    .sec_running(sec_running)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
    chk("R10", "cpu_clk_en", cpu_clk_en, 1);
    chk("R10", "per_clk_en", per_clk_en, 1);
    chk("R10", "src_sel", src_sel, 0);
    chk("R10", "pri_running", pri_running, 1);
    chk("R10", "sec_running", sec_running, 0);
    chk("R10", "pri_off_req", pri_off_req, 0);
  endtask

  task automatic t_primary_idle();
    clk_sel = 2'b00; idle_en = 1'b1; step();
    pulse_sleep();
    chk("R1", "cpu gated", cpu_clk_en, 0);
    chk("R1", "per running", per_clk_en, 1);
    chk("R6", "pri_running in idle", pri_running, 1);
    pulse_sleep();
    clk_sel = 2'b10; step(); step();
    chk("R2", "cpu still gated", cpu_clk_en, 0);
    chk("R4", "src held while gated", src_sel, 0);
    clk_sel = 2'b00;
    irq_wake = 1'b1; step(); irq_wake = 1'b0;
    chk("R3", "cpu resumed", cpu_clk_en, 1);
    chk("R3", "src after wake", src_sel, 0);
    chk("R6", "pri_running after wake", pri_running, 1);
  endtask

  task automatic t_secondary();
    clk_sel = 2'b01; step();
    chk("R4", "src secondary", src_sel, 1);
    chk("R6", "pri_running", pri_running, 0);
    chk("R6", "sec_running", sec_running, 1);
    chk("R7", "pri_off_req", pri_off_req, 1);
    pri_keep = 1'b1; step();
    chk("R7", "pri_off_req with keep", pri_off_req, 0);
    pri_keep = 1'b0;
    sec_osc_en = 1'b0; pulse_sleep();
    chk("R5", "refused entry", cpu_clk_en, 1);
    sec_osc_en = 1'b1; pulse_sleep();
    chk("R1", "secondary idle gated", cpu_clk_en, 0);
    chk("R1", "secondary idle per", per_clk_en, 1);
    wdt_wake = 1'b1; step(); wdt_wake = 1'b0;
    chk("R3", "wdt resume", cpu_clk_en, 1);
    chk("R3", "wdt resume src", src_sel, 1);
  endtask

  task automatic t_ready();
    clk_sel = 2'b01; sec_rdy = 1'b0; step();
    chk("R8", "sec not ready", per_clk_en, 0);
    sec_rdy = 1'b1; step();
    chk("R8", "sec ready", per_clk_en, 1);
    clk_sel = 2'b00; pri_rdy = 1'b0; step();
    chk("R8", "pri not ready", per_clk_en, 0);
    pri_rdy = 1'b1; step();
    chk("R8", "pri ready", per_clk_en, 1);
  endtask

  task automatic t_internal();
    clk_sel = 2'b10; step();
    chk("R4", "src internal", src_sel, 2);
    chk("R6", "pri flag internal", pri_running, 0);
    chk("R6", "sec flag internal", sec_running, 0);
    chk("R7", "off req internal", pri_off_req, 1);
    pulse_sleep();
    chk("R1", "internal idle", cpu_clk_en, 0);
    wdt_wake = 1'b1; step(); wdt_wake = 1'b0;
    chk("R3", "internal resume src", src_sel, 2);
    clk_sel = 2'b00; step();
  endtask

  task automatic t_full_sleep();
    idle_en = 1'b0; pulse_sleep();
    chk("R9", "cpu in sleep", cpu_clk_en, 0);
    chk("R9", "per in sleep", per_clk_en, 0);
    irq_wake = 1'b1; step(); irq_wake = 1'b0;
    chk("R9", "cpu after wake", cpu_clk_en, 1);
    chk("R9", "per after wake", per_clk_en, 1);
    idle_en = 1'b1;
  endtask

  task automatic t_collide();
    sleep_req = 1'b1; irq_wake = 1'b1; step();
    sleep_req = 1'b0; irq_wake = 1'b0;
    chk("R11", "sleep wins in run", cpu_clk_en, 0);
    sleep_req = 1'b1; wdt_wake = 1'b1; step();
    sleep_req = 1'b0; wdt_wake = 1'b0;
    chk("R11", "wake wins when gated", cpu_clk_en, 1);
  endtask

  task automatic t_reset_from_idle();
    clk_sel = 2'b01; step(); pulse_sleep();
    chk("R1", "idle before reset", cpu_clk_en, 0);
    rst = 1'b1; step(); rst = 1'b0;
    chk("R10", "cpu after reset", cpu_clk_en, 1);
    chk("R10", "src after reset", src_sel, 0);
    chk("R10", "pri flag after reset", pri_running, 1);
    chk("R10", "sec flag after reset", sec_running, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_primary_idle();
    t_secondary();
    t_ready();
    t_internal();
    t_full_sleep();
    t_collide();
    t_reset_from_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule